// File: doc/BRIEF.md
# Strided Multi-Vector Byte Load Sequencer

The block carries out one contiguous byte load that fills a group of two or four vector registers. The destination registers do not sit next to each other: they are spread across a 32-entry register file at a fixed stride. A decoded instruction arrives with a start pulse. It carries the base register index, a 4-bit signed vector offset, the group size, a high-half bit and a short register field. The block also receives the general-register and stack-pointer values and an already expanded per-element activity mask.

The sequencer computes the start address and then walks every byte element in order. For each active element it issues one read on a byte-wide memory port with a request/valid handshake. Each inactive element becomes a zero byte and causes no read. The address still advances by one byte for every element. When a vector is complete, it is written to its strided destination through a single register write port. A one-cycle done pulse closes the operation.

When the stack pointer is the base, no element of the group is active and the stack pointer is misaligned, the block raises a flag alongside done. The flag does not abort the load.

Top module: `strided_byte_loader`

## Requirements
- R1: Destination numbers. For a group of two (`grp4`=0), the first destination is {`t_bit`, 0, `zt_field[2:0]`} and the second adds 8. For a group of four (`grp4`=1), the first is {`t_bit`, 0, 0, `zt_field[1:0]`} and each later one adds 4. Writes come in ascending group order.
- R2: The start address is the base plus the sign-extended `imm4` times the group size (2 or 4) times 16 (the elements per vector at the default 128-bit vector length).
- R3: When `base_idx` is 31 the base is `sp_val`; otherwise it is `gpr_val`.
- R4: An active element raises `mem_req` with `mem_addr` at the current address. The request and the address stay unchanged until a cycle with `mem_valid` high, and that byte is taken.
- R5: An inactive element issues no request, and its byte in the written vector is zero.
- R6: The address advances by one after every element, active or not. Element k of the group therefore uses the start address plus k.
- R7: Element e of register r uses mask bit r*16+e, and its byte lands in `rf_wdata[8e+7:8e]`. For a group of two, mask bits 32 to 63 are ignored.
- R8: There is exactly one `rf_we` cycle per destination, and it comes only after all 16 bytes of that vector are gathered. No read is requested during a write cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the last register write. `busy` is high from the cycle after an accepted start through the done cycle, and low afterwards.
- R10: A `start` while `busy` is high is ignored. The running operation keeps the inputs it latched.
- R11: `sp_misalign` is high in the done cycle only when all of these hold: `base_idx` is 31, no mask bit used by the group is set, and `sp_val[3:0]` is nonzero. The load still completes and writes zero vectors.
- R12: During reset, `busy`, `done`, `rf_we`, `mem_req` and `sp_misalign` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accepts the instruction fields when idle |
| base_idx | input | 5 | Base register index; 31 selects the stack pointer |
| imm4 | input | 4 | Signed vector-group offset |
| grp4 | input | 1 | 1 = four destinations, 0 = two |
| t_bit | input | 1 | High-half select of the first destination |
| zt_field | input | 3 | Register field (low 2 bits used for four) |
| gpr_val | input | 64 | General-register base value |
| sp_val | input | 64 | Stack-pointer base value |
| elem_mask | input | 64 | Per-element activity, bit r*16+e |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 64 | Byte read address |
| mem_rdata | input | 8 | Read data |
| mem_valid | input | 1 | Read data valid, completes the request |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Destination register number |
| rf_wdata | output | 128 | Assembled vector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_misalign | output | 1 | Stack-pointer alignment flag, valid with done |

## Verification
The bench targets the cases a wrong design would corrupt without stalling. A negative offset checks the sign extension: an unsigned offset would fetch from an address far above the base. Sparse masks and upper-half mask bits in a two-register group check that the address advances on inactive elements and that out-of-group bits are ignored: a design that skipped the address step would shift every later byte, and one that read the upper bits would make extra reads. Empty masks with an aligned stack pointer, a misaligned stack pointer, and a general-register base check the alignment flag. A start pulsed mid-operation with different fields must leave the stride pattern and data of the running load intact.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ELEM  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } sbl_state_e;

  localparam logic [4:0] SBL_SP_INDEX = 5'd31;
  localparam int unsigned SBL_MAX_GRP = 4;
  localparam int unsigned SBL_GRP_W   = 2;
  localparam int unsigned SBL_REG_W   = 5;

endpackage

// File: rtl/sbl_addr_calc.sv
module sbl_addr_calc
  import sbl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned ELEMS    = 16,
  localparam int unsigned ELEM_LG2 = $clog2(ELEMS),
  localparam int unsigned MASK_W   = SBL_MAX_GRP * ELEMS,
  localparam int unsigned HALF_W   = MASK_W / 2
) (
  input  logic [SBL_REG_W-1:0] base_idx,
  input  logic [3:0]           imm4,
  input  logic                 grp4,
  input  logic [ADDR_W-1:0]    gpr_val,
  input  logic [ADDR_W-1:0]    sp_val,
  input  logic [MASK_W-1:0]    elem_mask,
  output logic [ADDR_W-1:0]    start_addr,
  output logic                 misalign
);

  logic              use_sp;
  logic [ADDR_W-1:0] base_sel;
  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] off_scaled;
  logic              any_active;

  always_comb begin
    use_sp   = (base_idx == SBL_SP_INDEX);
    base_sel = use_sp ? sp_val : gpr_val;
    off_ext  = {{(ADDR_W-4){imm4[3]}}, imm4};
    if (grp4) begin
      off_scaled = off_ext << (ELEM_LG2 + 2);
      any_active = |elem_mask;
    end else begin
      off_scaled = off_ext << (ELEM_LG2 + 1);
      any_active = |elem_mask[HALF_W-1:0];
    end
    start_addr = base_sel + off_scaled;
    misalign   = use_sp && !any_active && (sp_val[3:0] != 4'd0);
  end

endmodule

// File: rtl/sbl_dest_map.sv
module sbl_dest_map
  import sbl_pkg::*;
(
  input  logic                 grp4,
  input  logic                 t_bit,
  input  logic [2:0]           zt_field,
  input  logic [SBL_GRP_W-1:0] grp_idx,
  output logic [SBL_REG_W-1:0] dest
);

  logic [SBL_REG_W-1:0] first;
  logic [SBL_REG_W-1:0] step;

  always_comb begin
    if (grp4) begin
      first = {t_bit, 2'b00, zt_field[1:0]};
      step  = {1'b0, grp_idx, 2'b00};
    end else begin
      first = {t_bit, 1'b0, zt_field};
      step  = {1'b0, grp_idx[0], 3'b000};
    end
    dest = first + step;
  end

endmodule

// File: rtl/sbl_seq.sv
module sbl_seq
  import sbl_pkg::*;
#(
  parameter int unsigned VLEN   = 128,
  parameter int unsigned ADDR_W = 64,
  localparam int unsigned ELEMS  = VLEN / 8,
  localparam int unsigned ELEM_W = $clog2(ELEMS),
  localparam int unsigned MASK_W = SBL_MAX_GRP * ELEMS,
  localparam int unsigned IDX_W  = $clog2(MASK_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 grp4,
  input  logic                 t_bit,
  input  logic [2:0]           zt_field,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic                 misalign_in,
  input  logic [MASK_W-1:0]    elem_mask,
  input  logic [7:0]           mem_rdata,
  input  logic                 mem_valid,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 rf_we,
  output logic [VLEN-1:0]      rf_wdata,
  output logic                 busy,
  output logic                 done,
  output logic                 sp_misalign,
  output logic [SBL_GRP_W-1:0] grp_idx,
  output logic                 lat_grp4,
  output logic                 lat_t,
  output logic [2:0]           lat_zt
);

  sbl_state_e           state_q, state_d;
  logic [ADDR_W-1:0]    addr_q;
  logic [MASK_W-1:0]    mask_q;
  logic                 grp4_q, t_q, flag_q;
  logic [2:0]           zt_q;
  logic [SBL_GRP_W-1:0] r_q;
  logic [ELEM_W-1:0]    e_q;
  logic [7:0]           lane_q [ELEMS];

  logic accept, cur_active, step_en, wr_en, last_elem, last_grp;
  logic [IDX_W-1:0] bit_idx;
  logic [7:0] byte_in;

  // next-state and enables
  always_comb begin
    accept     = (state_q == ST_IDLE) && start;
    bit_idx    = {r_q, e_q};
    cur_active = mask_q[bit_idx];
    step_en    = (state_q == ST_ELEM) && (!cur_active || mem_valid);
    wr_en      = (state_q == ST_WRITE);
    last_elem  = (e_q == ELEM_W'(ELEMS - 1));
    last_grp   = (r_q == (grp4_q ? 2'd3 : 2'd1));
    byte_in    = cur_active ? mem_rdata : 8'h00;
    state_d    = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = ST_ELEM;
      ST_ELEM:  if (step_en && last_elem) state_d = ST_WRITE;
      ST_WRITE: state_d = last_grp ? ST_DONE : ST_ELEM;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      grp4_q  <= 1'b0;
      t_q     <= 1'b0;
      zt_q    <= '0;
      flag_q  <= 1'b0;
      r_q     <= '0;
      e_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= start_addr;
        mask_q <= elem_mask;
        grp4_q <= grp4;
        t_q    <= t_bit;
        zt_q   <= zt_field;
        flag_q <= misalign_in;
        r_q    <= '0;
        e_q    <= '0;
      end else begin
        if (step_en) begin
          addr_q <= addr_q + ADDR_W'(1);
          e_q    <= e_q + ELEM_W'(1);
        end
        if (wr_en) begin
          r_q <= r_q + SBL_GRP_W'(1);
        end
      end
    end
  end

  // one byte register per element lane
  for (genvar g = 0; g < ELEMS; g++) begin : g_lane
    logic lane_en;
    assign lane_en = step_en && (e_q == ELEM_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[g] <= 8'h00;
      end else if (lane_en) begin
        lane_q[g] <= byte_in;
      end
    end
    assign rf_wdata[8*g +: 8] = lane_q[g];
  end

  assign mem_req     = (state_q == ST_ELEM) && cur_active;
  assign mem_addr    = addr_q;
  assign rf_we       = wr_en;
  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_DONE);
  assign sp_misalign = done && flag_q;
  assign grp_idx     = r_q;
  assign lat_grp4    = grp4_q;
  assign lat_t       = t_q;
  assign lat_zt      = zt_q;

endmodule

// File: rtl/strided_byte_loader.sv
module strided_byte_loader
  import sbl_pkg::*;
#(
  parameter int unsigned VLEN   = 128,
  parameter int unsigned ADDR_W = 64,
  localparam int unsigned ELEMS  = VLEN / 8,
  localparam int unsigned MASK_W = SBL_MAX_GRP * ELEMS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [SBL_REG_W-1:0] base_idx,
  input  logic [3:0]           imm4,
  input  logic                 grp4,
  input  logic                 t_bit,
  input  logic [2:0]           zt_field,
  input  logic [ADDR_W-1:0]    gpr_val,
  input  logic [ADDR_W-1:0]    sp_val,
  input  logic [MASK_W-1:0]    elem_mask,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic [7:0]           mem_rdata,
  input  logic                 mem_valid,
  output logic                 rf_we,
  output logic [SBL_REG_W-1:0] rf_waddr,
  output logic [VLEN-1:0]      rf_wdata,
  output logic                 busy,
  output logic                 done,
  output logic                 sp_misalign
);

  logic [ADDR_W-1:0]    start_addr;
  logic                 misalign_w;
  logic [SBL_GRP_W-1:0] grp_idx;
  logic                 lat_grp4, lat_t;
  logic [2:0]           lat_zt;

  sbl_addr_calc #(.ADDR_W(ADDR_W), .ELEMS(ELEMS)) u_addr (
    .base_idx   (base_idx),
    .imm4       (imm4),
    .grp4       (grp4),
    .gpr_val    (gpr_val),
    .sp_val     (sp_val),
    .elem_mask  (elem_mask),
    .start_addr (start_addr),
    .misalign   (misalign_w)
  );

  sbl_seq #(.VLEN(VLEN), .ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .grp4        (grp4),
    .t_bit       (t_bit),
    .zt_field    (zt_field),
    .start_addr  (start_addr),
    .misalign_in (misalign_w),
    .elem_mask   (elem_mask),
    .mem_rdata   (mem_rdata),
    .mem_valid   (mem_valid),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .rf_we       (rf_we),
    .rf_wdata    (rf_wdata),
    .busy        (busy),
    .done        (done),
    .sp_misalign (sp_misalign),
    .grp_idx     (grp_idx),
    .lat_grp4    (lat_grp4),
    .lat_t       (lat_t),
    .lat_zt      (lat_zt)
  );

  sbl_dest_map u_dest (
    .grp4     (lat_grp4),
    .t_bit    (lat_t),
    .zt_field (lat_zt),
    .grp_idx  (grp_idx),
    .dest     (rf_waddr)
  );

endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rf_we,
  input logic              sp_misalign
);

  // R4: an unanswered request holds with the same address
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  // R6: after a completed read the next request uses a new address
  a_r6_addr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_valid |=> !mem_req || (mem_addr != $past(mem_addr)));

  // R8: writes occur inside the operation and never alongside a read
  a_r8_write_inside: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy && !done && !mem_req);

  // R9: done lasts one cycle and ends the operation
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R10: a running operation cannot be dropped by a new start
  a_r10_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  // R11: the alignment flag appears only with done
  a_r11_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    sp_misalign |-> done);

endmodule

bind strided_byte_loader sbl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .mem_req     (mem_req),
  .mem_valid   (mem_valid),
  .mem_addr    (mem_addr),
  .rf_we       (rf_we),
  .sp_misalign (sp_misalign)
);

// File: tb/sim_strided_byte_loader.sv
module sim_strided_byte_loader;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        grp4;
    logic        t;
    logic [2:0]  zt;
    logic [3:0]  imm;
    logic [4:0]  bidx;
    logic [3:0]  sp_lo;
    logic [63:0] mask;
    logic [1:0]  lat;
  } case_t;

  localparam case_t CASES [0:7] = '{
    '{1'b0, 1'b0, 3'd3, 4'd2, 5'd5,  4'h0, 64'h0000_0000_FFFF_FFFF, 2'd0},
    '{1'b1, 1'b1, 3'd2, 4'h8, 5'd31, 4'h0, 64'hA5A5_0F0F_F00F_1234, 2'd1},
    '{1'b0, 1'b1, 3'd7, 4'hF, 5'd31, 4'h8, 64'hFFFF_FFFF_8000_0001, 2'd2},
    '{1'b1, 1'b0, 3'd5, 4'd7, 5'd0,  4'h0, 64'h8000_0000_0000_0001, 2'd3},
    '{1'b1, 1'b0, 3'd0, 4'd0, 5'd31, 4'h4, 64'h0000_0000_0000_0000, 2'd0},
    '{1'b0, 1'b0, 3'd1, 4'd0, 5'd31, 4'h0, 64'h0000_0000_0000_0000, 2'd0},
    '{1'b0, 1'b0, 3'd4, 4'd3, 5'd31, 4'hC, 64'hFFFF_FFFF_0000_0000, 2'd1},
    '{1'b0, 1'b1, 3'd6, 4'd0, 5'd9,  4'h4, 64'h0000_0000_0000_0000, 2'd0}
  };

  localparam logic [63:0] GPR = 64'h0000_0001_0000_0800;
  localparam logic [63:0] SPB = 64'h0000_0000_0000_4000;

  logic         clk, rst_n, start;
  logic [4:0]   base_idx;
  logic [3:0]   imm4;
  logic         grp4, t_bit;
  logic [2:0]   zt_field;
  logic [63:0]  gpr_val, sp_val, elem_mask;
  logic         mem_req, mem_valid;
  logic [63:0]  mem_addr;
  logic [7:0]   mem_rdata;
  logic         rf_we, busy, done, sp_misalign;
  logic [4:0]   rf_waddr;
  logic [127:0] rf_wdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int cur_lat = 0;
  int lat_cnt = 0;
  int rd_cnt  = 0;

  strided_byte_loader u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_idx(base_idx), .imm4(imm4),
    .grp4(grp4), .t_bit(t_bit), .zt_field(zt_field), .gpr_val(gpr_val),
    .sp_val(sp_val), .elem_mask(elem_mask), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .busy(busy),
    .done(done), .sp_misalign(sp_misalign)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memf(input logic [63:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory model: answers a held request after cur_lat waiting cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_valid = 1'b0;
      lat_cnt   = 0;
    end else if (mem_req) begin
      if (lat_cnt >= cur_lat) begin
        mem_valid = 1'b1;
        mem_rdata = memf(mem_addr);
        rd_cnt++;
        lat_cnt = 0;
      end else begin
        mem_valid = 1'b0;
        lat_cnt++;
      end
    end else begin
      mem_valid = 1'b0;
      lat_cnt   = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R9 watchdog act=%0d exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_case(input case_t c, input bit poke);
    logic [63:0]  base, start_a, off, nreg;
    logic [4:0]   dest0, stride;
    logic [127:0] ed;
    logic [4:0]   waddr [4];
    logic [127:0] wdata [4];
    int           wcnt, exp_reads, nr, n;
    bit           seen_done, flag, exp_flag;

    nr       = c.grp4 ? 4 : 2;
    nreg     = 64'(nr);
    base     = (c.bidx == 5'd31) ? (SPB | {60'd0, c.sp_lo}) : GPR;
    off      = {{60{c.imm[3]}}, c.imm};
    start_a  = base + off * nreg * 64'd16;
    dest0    = c.grp4 ? {c.t, 2'b00, c.zt[1:0]} : {c.t, 1'b0, c.zt};
    stride   = c.grp4 ? 5'd4 : 5'd8;
    exp_reads = 0;
    for (int i = 0; i < nr * 16; i++) if (c.mask[i]) exp_reads++;
    exp_flag = (c.bidx == 5'd31) && (exp_reads == 0) && (c.sp_lo != 4'h0);

    cur_lat = int'(c.lat);
    rd_cnt  = 0;
    wcnt    = 0;
    seen_done = 1'b0;
    flag    = 1'b0;

    @(negedge clk);
    grp4 = c.grp4; t_bit = c.t; zt_field = c.zt; imm4 = c.imm;
    base_idx = c.bidx; sp_val = SPB | {60'd0, c.sp_lo}; gpr_val = GPR;
    elem_mask = c.mask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", 128'(busy), 128'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      grp4 = ~c.grp4; t_bit = ~c.t; zt_field = ~c.zt; imm4 = 4'd5;
      base_idx = 5'd3; elem_mask = '1; gpr_val = 64'hDEAD_0000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!seen_done && n < 4000) begin
      @(negedge clk);
      n++;
      if (rf_we) begin
        if (wcnt < 4) begin
          waddr[wcnt] = rf_waddr;
          wdata[wcnt] = rf_wdata;
        end
        wcnt++;
      end
      if (done) begin
        seen_done = 1'b1;
        flag = sp_misalign;
      end
    end
    chk(seen_done, "R9 done reached", 128'(seen_done), 128'd1);
    chk(wcnt == nr, "R8 write count", 128'(wcnt), 128'(nr));
    for (int r = 0; r < nr && r < wcnt; r++) begin
      for (int e = 0; e < 16; e++)
        ed[8*e +: 8] = c.mask[r*16 + e] ? memf(start_a + 64'(r*16 + e)) : 8'h00;
      chk(waddr[r] == dest0 + 5'(r) * stride, "R1 destination", 128'(waddr[r]),
          128'(dest0 + 5'(r) * stride));
      chk(wdata[r] == ed, "R2 R3 R6 R7 vector data", wdata[r], ed);
    end
    chk(rd_cnt == exp_reads, "R5 read count", 128'(rd_cnt), 128'(exp_reads));
    chk(flag == exp_flag, "R11 alignment flag", 128'(flag), 128'(exp_flag));
    @(negedge clk);
    chk(!busy && !done, "R9 idle after done", 128'({busy, done}), 128'd0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; base_idx = '0; imm4 = '0; grp4 = 1'b0;
    t_bit = 1'b0; zt_field = '0; gpr_val = '0; sp_val = '0; elem_mask = '0;
    mem_valid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, rf_we, mem_req, sp_misalign} == 5'b0, "R12 reset outputs",
        128'({busy, done, rf_we, mem_req, sp_misalign}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R12 idle after reset", 128'(busy), 128'd0);

    // table of vectors: strides, offsets, bases, masks, latencies, flag cases
    for (int i = 0; i < 8; i++) run_case(CASES[i], 1'b0);

    // R10: start pulsed mid-operation with different fields is ignored
    run_case(CASES[1], 1'b1);
    run_case(CASES[2], 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule